// File: doc/BRIEF.md
# Transaction Energy Feature Estimator

This block turns the data of one 128-byte memory transaction into a linear estimate of the energy that the data moves across the memory path. The estimate depends only on the data. As the payload streams in, the block derives a set of features from it. One feature counts the zero bits, because on open-drain style data lines a low level draws current. The other features count how often each wire would toggle if the payload were sent over a link of a given width. Every feature is also computed a second time, on a copy of the payload that has been through byte-wise data-inversion coding.

The features are collected over the eight beats of the payload. A serial multiply-accumulate then weights each feature with a 16-bit programmable coefficient and sums the products. The sum is divided by 512, because the coefficients are scaled per 512 bit flips. A reference payload of all ones has zero cost for every feature, so the estimate is the energy above that reference. Calibrating the coefficients is left to whatever writes the coefficient bank.

Top module: `energy_estimator`

## Requirements
- R1: The payload is delivered as eight beats of 128 bits. A beat transfers at a rising edge where both `inValid` and `inReady` are high. Payload bit 128*j+k is bit k of beat j, and beat 0 is the first beat sent.
- R2: After reset `inReady` is high. It goes low from the cycle after the eighth beat is taken and stays low until the estimate has been presented. It is high again in the cycle after `estValid`.
- R3: `estValid` is high for exactly one cycle. That cycle begins at the 14th rising edge after the edge that takes the last beat.
- R4: Feature 0 is the number of zero bits in the 1024-bit payload, which is 1024 minus its population count.
- R5: Features 1 to 6 are raw toggle counts for link widths of 1, 2, 4, 8, 32 and 64 bytes, in that order. The 4-byte width is also the 32-bit DRAM lane. For a width of W bytes, payload bit i is compared with bit i-8W. The first link beat is compared with all ones.
- R6: In the inverted-coding copy, each byte that holds more than four zeros is sent inverted with a flag bit of 0. Every other byte is sent unchanged with a flag of 1. Byte L becomes the 9-bit group at bits 9L to 9L+8 of a 1152-bit stream, with the flag in the top bit. Feature 7 counts the zeros of that stream, flags included.
- R7: Features 8 to 13 are toggle counts of the coded stream for the same six widths, in the same order. A link beat of W bytes spans 9W bits, and the first link beat is compared with all ones.
- R8: The coefficient for feature n is written at address n through `coefWe`, `coefAddr` and `coefData`. The estimate is the sum over all features of coefficient times feature, divided by 512 and rounded down. A zero coefficient removes its feature from the sum.
- R9: With every coefficient at 65535 and an all-zero payload, the estimate is exact and does not wrap.
- R10: An all-ones payload gives an estimate of 0 for any coefficients.
- R11: Reset clears all coefficients to zero, so the first estimate after reset is 0 for any payload. After reset `estValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload beat present on `inData` |
| inReady | output | 1 | Block accepts a payload beat |
| inData | input | 128 | Payload beat |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient index (0 to 13) |
| coefData | input | 16 | Unsigned coefficient value |
| estValid | output | 1 | Estimate valid, one-cycle pulse |
| estimate | output | 22 | Energy estimate, weighted sum divided by 512 |

## Verification
Each feature is checked on its own: a single coefficient is set to 512 to read the feature exactly, and to 777 to exercise truncation. This runs over payloads of all ones, all zeros, alternating bits, pseudo-random data, and bytes holding exactly four zeros and exactly five zeros. A design that inverts at four zeros, or that leaves the flag out of the counts, returns the wrong coded zero count on the byte-boundary payloads. A wrong start state for the first beat moves every toggle feature of the all-zero payload. Mixing up cross-beat history shows up only at the 32-byte and 64-byte widths on random data. The all-maximum coefficient case catches an accumulator that is too narrow. The handshake checks catch a block that takes data while it is computing, or that reports the estimate at the wrong time.

// File: rtl/energy_est_pkg.sv
package energy_est_pkg;

  // Link widths (bytes) for which toggle features are formed; order fixes feature index.
  localparam int NUM_LINKS = 6;
  localparam int LINK_BYTES [NUM_LINKS] = '{1, 2, 4, 8, 32, 64};
  localparam int MAX_LINK_BYTES = 64;

  // One zero-count feature plus one toggle feature per link, raw and coded.
  localparam int FEATS_PER_SET = NUM_LINKS + 1;
  localparam int NUM_FEAT = 2 * FEATS_PER_SET;
  localparam int FEAT_IDX_W = $clog2(NUM_FEAT);

  // Bits per coded lane: eight data bits and one inversion flag.
  localparam int CODED_LANE_W = 9;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_MAC     = 2'd1,
    ST_OUT     = 2'd2
  } estState_t;

  typedef struct packed {
    logic                  accept;
    logic                  first;
    logic                  macStep;
    logic [FEAT_IDX_W-1:0] macIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/energy_toggle_unit.sv
module energy_toggle_unit #(
  parameter int VEC_W      = 128,
  parameter int SPAN_W     = 8,
  parameter int HIST_DEPTH = 4,
  parameter int CNT_W      = 8
) (
  input  logic [VEC_W-1:0]                 cur,
  input  logic [HIST_DEPTH-1:0][VEC_W-1:0] hist,
  output logic [CNT_W-1:0]                 count
);

  logic [VEC_W-1:0] cmpVec;

  generate
    if (SPAN_W < VEC_W) begin : g_narrow
      // Link beat fits inside one input beat: bit i meets bit i-SPAN_W,
      // the lowest link beat meets the top of the previous input beat.
      assign cmpVec = {cur[VEC_W-SPAN_W-1:0], hist[0][VEC_W-1 -: SPAN_W]};
    end else begin : g_wide
      // Link beat spans whole input beats: compare with the beat SPAN_W bits back.
      assign cmpVec = hist[SPAN_W/VEC_W - 1];
    end
  endgenerate

  assign count = CNT_W'($countones(cur ^ cmpVec));

endmodule

// File: rtl/energy_ctrl.sv
module energy_ctrl
  import energy_est_pkg::*;
#(
  parameter int BEATS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         estValid,
  output ctrlStrobes_t st
);

  localparam int BEAT_CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_CNT_W-1:0] LAST_BEAT = BEAT_CNT_W'(BEATS - 1);
  localparam logic [FEAT_IDX_W-1:0] LAST_FEAT = FEAT_IDX_W'(NUM_FEAT - 1);

  estState_t             state;
  logic [BEAT_CNT_W-1:0] beatCnt;
  logic [FEAT_IDX_W-1:0] macIdx;
  logic                  accept;
  logic                  lastBeat;

  assign inReady  = (state == ST_COLLECT);
  assign accept   = inValid && inReady;
  assign lastBeat = (beatCnt == LAST_BEAT);
  assign estValid = (state == ST_OUT);

  assign st.accept  = accept;
  assign st.first   = (beatCnt == '0);
  assign st.macStep = (state == ST_MAC);
  assign st.macIdx  = macIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_COLLECT;
      beatCnt <= '0;
      macIdx  <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (accept) begin
            if (lastBeat) begin
              beatCnt <= '0;
              macIdx  <= '0;
              state   <= ST_MAC;
            end else begin
              beatCnt <= beatCnt + 1'b1;
            end
          end
        end
        ST_MAC: begin
          macIdx <= macIdx + 1'b1;
          if (macIdx == LAST_FEAT) state <= ST_OUT;
        end
        ST_OUT:  state <= ST_COLLECT;
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // R3: the estimate is presented for a single cycle only.
  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    estValid |=> !estValid);

  // R2: once the final beat is taken, no further beat is accepted next cycle.
  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastBeat) |=> !inReady);

endmodule

// File: rtl/energy_dp.sv
module energy_dp
  import energy_est_pkg::*;
#(
  parameter int BEAT_W        = 128,
  parameter int PAYLOAD_BYTES = 128,
  parameter int COEF_W        = 16,
  parameter int FEAT_W        = 11,
  parameter int ACC_W         = 31,
  parameter int SCALE_SHIFT   = 9,
  parameter int HIST_DEPTH    = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 st,
  input  logic [BEAT_W-1:0]            inData,
  input  logic                         coefWe,
  input  logic [FEAT_IDX_W-1:0]        coefAddr,
  input  logic [COEF_W-1:0]            coefData,
  output logic [ACC_W-SCALE_SHIFT-1:0] estimate
);

  localparam int BEAT_BYTES   = BEAT_W / 8;
  localparam int ENC_W        = BEAT_BYTES * CODED_LANE_W;
  localparam int PAYLOAD_BITS = PAYLOAD_BYTES * 8;
  localparam int DELTA_W      = $clog2(ENC_W + 1);

  // ---------------- byte-lane inversion coding ----------------
  logic [ENC_W-1:0] encBeat;

  generate
    for (genvar l = 0; l < BEAT_BYTES; l++) begin : g_lane
      logic [7:0] laneByte;
      logic [3:0] laneZeros;
      assign laneByte  = inData[8*l +: 8];
      assign laneZeros = 4'(8 - $countones(laneByte));
      assign encBeat[CODED_LANE_W*l +: CODED_LANE_W] =
        (laneZeros > 4'd4) ? {1'b0, ~laneByte} : {1'b1, laneByte};
    end
  endgenerate

  // ---------------- beat history (first beat sees all ones) ----------------
  logic [HIST_DEPTH-1:0][BEAT_W-1:0] histRaw, effRaw;
  logic [HIST_DEPTH-1:0][ENC_W-1:0]  histEnc, effEnc;

  assign effRaw = st.first ? '1 : histRaw;
  assign effEnc = st.first ? '1 : histEnc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      histRaw <= '1;
      histEnc <= '1;
    end else if (st.accept) begin
      for (int k = HIST_DEPTH - 1; k > 0; k--) begin
        histRaw[k] <= effRaw[k-1];
        histEnc[k] <= effEnc[k-1];
      end
      histRaw[0] <= inData;
      histEnc[0] <= encBeat;
    end
  end

  // ---------------- per-beat feature increments ----------------
  logic [NUM_FEAT-1:0][DELTA_W-1:0] delta;

  assign delta[0]             = DELTA_W'(BEAT_W - $countones(inData));
  assign delta[FEATS_PER_SET] = DELTA_W'(ENC_W - $countones(encBeat));

  generate
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
      energy_toggle_unit #(
        .VEC_W      (BEAT_W),
        .SPAN_W     (8 * LINK_BYTES[g]),
        .HIST_DEPTH (HIST_DEPTH),
        .CNT_W      (DELTA_W)
      ) u_rawTog (
        .cur   (inData),
        .hist  (effRaw),
        .count (delta[1 + g])
      );

      energy_toggle_unit #(
        .VEC_W      (ENC_W),
        .SPAN_W     (CODED_LANE_W * LINK_BYTES[g]),
        .HIST_DEPTH (HIST_DEPTH),
        .CNT_W      (DELTA_W)
      ) u_encTog (
        .cur   (encBeat),
        .hist  (effEnc),
        .count (delta[FEATS_PER_SET + 1 + g])
      );
    end
  endgenerate

  // ---------------- feature accumulators ----------------
  logic [NUM_FEAT-1:0][FEAT_W-1:0] featReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featReg <= '0;
    end else if (st.accept) begin
      for (int i = 0; i < NUM_FEAT; i++) begin
        featReg[i] <= (st.first ? FEAT_W'(0) : featReg[i]) + FEAT_W'(delta[i]);
      end
    end
  end

  // ---------------- coefficient bank ----------------
  logic [NUM_FEAT-1:0][COEF_W-1:0] coefBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coefBank <= '0;
    end else if (coefWe && (int'(coefAddr) < NUM_FEAT)) begin
      coefBank[coefAddr] <= coefData;
    end
  end

  // ---------------- serial multiply-accumulate ----------------
  logic [ACC_W-1:0] acc, accNext;

  assign accNext = acc + (ACC_W'(coefBank[st.macIdx]) * ACC_W'(featReg[st.macIdx]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (st.accept && st.first) begin
      acc <= '0;
    end else if (st.macStep) begin
      acc <= accNext;
    end
  end

  assign estimate = acc[ACC_W-1:SCALE_SHIFT];

  // R9: every accumulation step grows the sum without wrapping.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.macStep |-> (accNext >= acc));

  // R4: the zero count never exceeds the payload size.
  assert_zero_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(featReg[0]) <= PAYLOAD_BITS);

  // R6: coding never leaves more zeros than the raw data had.
  assert_coded_zeros_R6: assert property (@(posedge clk) disable iff (!rstN)
    featReg[FEATS_PER_SET] <= featReg[0]);

endmodule

// File: rtl/energy_estimator.sv
module energy_estimator
  import energy_est_pkg::*;
#(
  parameter int BEAT_W        = 128,
  parameter int PAYLOAD_BYTES = 128,
  parameter int COEF_W        = 16,
  parameter int SCALE_SHIFT   = 9
) (
  input  logic                                                   clk,
  input  logic                                                   rstN,
  input  logic                                                   inValid,
  output logic                                                   inReady,
  input  logic [BEAT_W-1:0]                                      inData,
  input  logic                                                   coefWe,
  input  logic [FEAT_IDX_W-1:0]                                  coefAddr,
  input  logic [COEF_W-1:0]                                      coefData,
  output logic                                                   estValid,
  output logic [COEF_W+$clog2(PAYLOAD_BYTES*CODED_LANE_W+1)+FEAT_IDX_W-SCALE_SHIFT-1:0] estimate
);

  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int BEATS      = PAYLOAD_BYTES / BEAT_BYTES;
  localparam int FEAT_W     = $clog2(PAYLOAD_BYTES * CODED_LANE_W + 1);
  localparam int ACC_W      = COEF_W + FEAT_W + FEAT_IDX_W;
  localparam int HIST_DEPTH = (MAX_LINK_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;

  ctrlStrobes_t st;

  energy_ctrl #(
    .BEATS (BEATS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .estValid (estValid),
    .st       (st)
  );

  energy_dp #(
    .BEAT_W        (BEAT_W),
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .COEF_W        (COEF_W),
    .FEAT_W        (FEAT_W),
    .ACC_W         (ACC_W),
    .SCALE_SHIFT   (SCALE_SHIFT),
    .HIST_DEPTH    (HIST_DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .inData   (inData),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .estimate (estimate)
  );

endmodule

// File: tb/energy_estimator_tb.sv
module energy_estimator_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 14;
  localparam int PB = 1024;
  localparam int EB = 1152;
  localparam int EXP_LAT = 14;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [127:0] inData;
  logic         coefWe;
  logic [3:0]   coefAddr;
  logic [15:0]  coefData;
  logic         estValid;
  logic [21:0]  estimate;

  int checks = 0;
  int errors = 0;
  logic [15:0] coefModel [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  energy_estimator u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .estValid(estValid), .estimate(estimate)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [EB-1:0] encodeDbi(input logic [PB-1:0] p);
    logic [EB-1:0] e;
    for (int l = 0; l < 128; l++) begin
      logic [7:0] b;
      b = p[8*l +: 8];
      if ((8 - $countones(b)) > 4) e[9*l +: 9] = {1'b0, ~b};
      else                         e[9*l +: 9] = {1'b1, b};
    end
    return e;
  endfunction

  // R4..R7 model: zero counts and toggle counts against bit i-span, start all ones.
  function automatic int featureOf(input logic [PB-1:0] p, input int f);
    logic [EB-1:0] v;
    int n, lane, g, cnt, span;
    int wl [6] = '{1, 2, 4, 8, 32, 64};
    if (f < 7) begin v = '1; v[PB-1:0] = p; n = PB; lane = 8; g = f; end
    else       begin v = encodeDbi(p);      n = EB; lane = 9; g = f - 7; end
    cnt = 0;
    if (g == 0) begin
      for (int i = 0; i < n; i++) cnt += (v[i] == 1'b0) ? 1 : 0;
    end else begin
      span = lane * wl[g-1];
      for (int i = 0; i < n; i++) begin
        logic pb;
        pb = (i >= span) ? v[i-span] : 1'b1;
        cnt += (v[i] ^ pb) ? 1 : 0;
      end
    end
    return cnt;
  endfunction

  function automatic longint expectEst(input logic [PB-1:0] p);
    longint s = 0;
    for (int f = 0; f < NF; f++) s += longint'(coefModel[f]) * featureOf(p, f);
    return s >> 9;
  endfunction

  function automatic string tagOf(input int f);
    if (f == 0) return "R4";
    if (f < 7)  return "R5";
    if (f == 7) return "R6";
    return "R7";
  endfunction

  function automatic logic [PB-1:0] genPayload(input int kind);
    logic [PB-1:0] p;
    logic [31:0] s;
    case (kind)
      0: p = '1;
      1: p = '0;
      2: p = {128{8'h55}};
      3: p = {128{8'hE0}};   // five zeros per byte: coded inverted
      4: p = {128{8'hF0}};   // four zeros per byte: sent as is
      default: begin
        s = 32'h1234_5678 + 32'(kind) * 32'h9E37_79B9;
        for (int w = 0; w < 32; w++) begin
          s ^= s << 13; s ^= s >> 17; s ^= s << 5;
          p[32*w +: 32] = s;
        end
      end
    endcase
    return p;
  endfunction

  task automatic writeCoef(input int a, input logic [15:0] v);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = 4'(a); coefData = v;
    @(negedge clk);
    coefWe = 1'b0;
    coefModel[a] = v;
  endtask

  task automatic runPayload(input logic [PB-1:0] p, output longint est);
    int lat;
    bit busyOk;
    bit readyOk;
    readyOk = 1'b1;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      if (!inReady) readyOk = 1'b0;
      inValid = 1'b1;
      inData  = p[128*j +: 128];
    end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R1 ready during beats", readyOk, 1);
    busyOk = !inReady;
    lat = 0;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (estValid) break;
      if (inReady) busyOk = 1'b0;
    end
    est = estimate;
    check("R2 ready low while busy", busyOk, 1);
    check("R3 latency", lat, EXP_LAT);
    @(negedge clk);
    check("R3 single-cycle valid", estValid, 0);
    check("R2 ready back", inReady, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint est;
    logic [PB-1:0] p;
    int vals [2] = '{512, 777};
    rstN = 1'b0; inValid = 1'b0; inData = '0;
    coefWe = 1'b0; coefAddr = '0; coefData = '0;
    for (int f = 0; f < NF; f++) coefModel[f] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R11 reset estValid", estValid, 0);
    check("R11 reset inReady", inReady, 1);

    // R11: coefficients cleared by reset.
    runPayload(genPayload(5), est);
    check("R11 zero coefficients", est, 0);

    // One-hot coefficient sweep over all features and payload kinds.
    for (int vi = 0; vi < 2; vi++) begin
      for (int f = 0; f < NF; f++) begin
        writeCoef(f, 16'(vals[vi]));
        for (int k = 0; k < 8; k++) begin
          p = genPayload(k);
          runPayload(p, est);
          check($sformatf("%s%s feat%0d coef%0d kind%0d", tagOf(f),
                          (vi == 1) ? "/R8" : (k >= 5 ? "/R1" : ""), f, vals[vi], k),
                est, expectEst(p));
        end
        writeCoef(f, 16'd0);
      end
    end

    // R8: mixed coefficients, weighted sum over all features.
    for (int f = 0; f < NF; f++) writeCoef(f, 16'(113 * f + 29));
    for (int k = 1; k < 8; k++) begin
      p = genPayload(k);
      runPayload(p, est);
      check($sformatf("R8 mixed kind%0d", k), est, expectEst(p));
    end

    // R9 / R10: all coefficients at maximum.
    for (int f = 0; f < NF; f++) writeCoef(f, 16'hFFFF);
    p = genPayload(1);
    runPayload(p, est);
    check("R9 max coefficients, all-zero payload", est, expectEst(p));
    p = genPayload(0);
    runPayload(p, est);
    check("R10 all-ones payload", est, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule